// File: doc/BRIEF.md
# Burst Address Generator with Run-Time Order Select

This block supplies the word address for a synchronous burst memory. A burst begins when either of two start strobes is sampled. One strobe is the processor-side strobe and the other is the controller-side strobe. The starting strobe captures the external address bus. The low address bits then step through an aligned group of four, one beat for each cycle in which the advance input is high. The upper address bits keep the captured value until the next load.

The beat order is chosen when the address is loaded. Linear order adds the beat count to the starting low bits, modulo four. Interleaved order XORs the beat count into the starting low bits. The burst feature is optional: a strobe may be issued on every cycle, and each strobe presents its new address right after the capturing edge. The output comes directly from registered state, so it changes only on clock edges.

Top module: `bag_burst_addr`

## Requirements
- R1: While rst_ni is low, addr_o is 0.
- R2: A processor-side strobe (strobe_cpu_i=1) loads addr_i whatever the level of cen_i. After that edge, addr_o equals the loaded address and the beat count is 0.
- R3: The controller-side strobe (strobe_ctl_i=1) loads addr_i only when cen_i=1. When cen_i=0 the strobe is ignored, and addr_o follows the advance/hold rule as if no strobe were present.
- R4: With no load, adv_i=1 advances the beat count by one at the edge, and adv_i=0 leaves addr_o unchanged.
- R5: In linear order (order_i=0 at load), addr_o[1:0] = (start[1:0] + beat) mod 4.
- R6: In interleaved order (order_i=1 at load), addr_o[1:0] = start[1:0] XOR beat.
- R7: addr_o[ADDR_W-1:2] stays equal to the loaded address for the whole burst.
- R8: After the fourth beat the count wraps to 0. The burst keeps cycling inside the same group of four until a new load.
- R9: order_i is sampled only on a load edge. Changes to it during a burst have no effect.
- R10: A load takes priority over adv_i in the same cycle, so the beat count restarts at 0. When both strobes are high, exactly one load of addr_i happens.
- R11: Back-to-back loads on consecutive cycles each appear on addr_o one edge later, with no lost cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| strobe_cpu_i | input | 1 | Processor-side burst start strobe |
| strobe_ctl_i | input | 1 | Controller-side burst start strobe, qualified by cen_i |
| cen_i | input | 1 | Chip enable, active high |
| adv_i | input | 1 | Advance the burst by one beat |
| order_i | input | 1 | Beat order at load: 0 linear, 1 interleaved |
| addr_i | input | ADDR_W | External start address |
| addr_o | output | ADDR_W | Current internal address |

## Verification
Bursts are run in both orders from every possible starting offset. Runs of more than four advances tell wrap-around apart from carry into the upper bits. Gaps in adv_i show whether the count truly stalls. A controller-side strobe is given with and without chip enable, which separates a qualified load from an ignored one. Simultaneous strobes and strobes combined with adv_i show that a load restarts the count. A stream of loads on every cycle and order_i toggled mid-burst show that the order is captured only on the load edge.

// File: rtl/bag_pkg.sv
package bag_pkg;
  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } order_e;
endpackage

// File: rtl/bag_load_ctrl.sv
module bag_load_ctrl (
  input  logic strobe_cpu_i,
  input  logic strobe_ctl_i,
  input  logic cen_i,
  input  logic adv_i,
  output logic load_o,
  output logic step_o
);
  logic ctl_qual;

  // controller strobe needs chip enable; processor strobe does not
  assign ctl_qual = strobe_ctl_i & cen_i;
  assign load_o   = strobe_cpu_i | ctl_qual;
  assign step_o   = adv_i & ~load_o;
endmodule

// File: rtl/bag_beat_cnt.sv
module bag_beat_cnt #(
  parameter int BEAT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              step_i,
  output logic [BEAT_W-1:0] beat_o
);
  logic [BEAT_W-1:0] beat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      beat_q <= '0;
    else if (clear_i) beat_q <= '0;
    else if (step_i)  beat_q <= beat_q + 1'b1;  // natural wrap
  end

  assign beat_o = beat_q;
endmodule

// File: rtl/bag_order_map.sv
module bag_order_map
  import bag_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic [BEAT_W-1:0] start_i,
  input  logic [BEAT_W-1:0] beat_i,
  input  order_e            order_i,
  output logic [BEAT_W-1:0] low_o
);
  logic [BEAT_W-1:0] lin_low;
  logic [BEAT_W-1:0] xor_low;

  assign lin_low = start_i + beat_i;

  for (genvar b = 0; b < BEAT_W; b++) begin : g_xor
    assign xor_low[b] = start_i[b] ^ beat_i[b];
  end

  always_comb begin
    unique case (order_i)
      ORD_XOR: low_o = xor_low;
      default: low_o = lin_low;
    endcase
  end
endmodule

// File: rtl/bag_burst_addr.sv
module bag_burst_addr
  import bag_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int BEAT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strobe_cpu_i,
  input  logic              strobe_ctl_i,
  input  logic              cen_i,
  input  logic              adv_i,
  input  logic              order_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int HI_W = ADDR_W - BEAT_W;

  logic              load;
  logic              step;
  logic [ADDR_W-1:0] base_q;
  order_e            order_q;
  logic [BEAT_W-1:0] beat;
  logic [BEAT_W-1:0] low;

  bag_load_ctrl u_load (
    .strobe_cpu_i (strobe_cpu_i),
    .strobe_ctl_i (strobe_ctl_i),
    .cen_i        (cen_i),
    .adv_i        (adv_i),
    .load_o       (load),
    .step_o       (step)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q  <= '0;
      order_q <= ORD_LINEAR;
    end else if (load) begin
      base_q  <= addr_i;
      order_q <= order_e'(order_i);  // order latched only here
    end
  end

  bag_beat_cnt #(.BEAT_W(BEAT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (load),
    .step_i  (step),
    .beat_o  (beat)
  );

  bag_order_map #(.BEAT_W(BEAT_W)) u_map (
    .start_i (base_q[BEAT_W-1:0]),
    .beat_i  (beat),
    .order_i (order_q),
    .low_o   (low)
  );

  assign addr_o = {base_q[ADDR_W-1:BEAT_W], low};

  initial begin
    if (HI_W < 1) $error("ADDR_W must exceed BEAT_W");
  end
endmodule

// File: rtl/bag_burst_addr_chk.sv
module bag_burst_addr_chk #(
  parameter int ADDR_W = 20,
  parameter int BEAT_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              strobe_cpu_i,
  input logic              strobe_ctl_i,
  input logic              cen_i,
  input logic              adv_i,
  input logic              order_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [ADDR_W-1:0] addr_o
);
  logic ld;
  assign ld = strobe_cpu_i | (strobe_ctl_i & cen_i);

  // R1
  reset_zero_chk: assert property (@(posedge clk_i) !rst_ni |-> addr_o == '0);

  // R2
  load_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld |=> addr_o == $past(addr_i));

  // R4
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld && !adv_i) |=> $stable(addr_o));

  // R4
  step_moves_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld && adv_i) |=> addr_o != $past(addr_o));

  // R7
  upper_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld |=> addr_o[ADDR_W-1:BEAT_W] == $past(addr_o[ADDR_W-1:BEAT_W]));

  // R3
  ctl_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_ctl_i && !cen_i && !strobe_cpu_i && !adv_i) |=> $stable(addr_o));
endmodule

bind bag_burst_addr bag_burst_addr_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .strobe_cpu_i (strobe_cpu_i),
  .strobe_ctl_i (strobe_ctl_i),
  .cen_i        (cen_i),
  .adv_i        (adv_i),
  .order_i      (order_i),
  .addr_i       (addr_i),
  .addr_o       (addr_o)
);

// File: tb/sim_bag_burst_addr.sv
module sim_bag_burst_addr;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          s_cpu = 1'b0, s_ctl = 1'b0, cen = 1'b0, adv = 1'b0, ord = 1'b0;
  logic [AW-1:0] a_in = '0;
  logic [AW-1:0] a_out;

  int n_run = 0;
  int n_fail = 0;

  // reference state
  logic [AW-1:0] m_base = '0;
  int            m_beat = 0;
  logic          m_mode = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bag_burst_addr u0 (
    .clk_i(clk), .rst_ni(rst_ni), .strobe_cpu_i(s_cpu), .strobe_ctl_i(s_ctl),
    .cen_i(cen), .adv_i(adv), .order_i(ord), .addr_i(a_in), .addr_o(a_out)
  );

  function automatic logic [AW-1:0] model_addr();
    int s = int'(m_base[1:0]);
    int lowv = m_mode ? (s ^ m_beat) : ((s + m_beat) % 4);
    return {m_base[AW-1:2], 2'(lowv)};
  endfunction

  task automatic check(string tag, logic [AW-1:0] exp);
    n_run++;
    if (a_out !== exp) begin
      n_fail++;
      $display("FAIL %s addr_o=%h expected=%h", tag, a_out, exp);
    end
  endtask

  // inputs applied at negedge, model updated at posedge, checked at next negedge
  task automatic cyc(string tag, logic cpu, logic ctl, logic ce, logic av,
                     logic od, logic [AW-1:0] a);
    s_cpu = cpu; s_ctl = ctl; cen = ce; adv = av; ord = od; a_in = a;
    @(posedge clk);
    if (cpu || (ctl && ce)) begin
      m_base = a; m_beat = 0; m_mode = od;
    end else if (av) begin
      m_beat = (m_beat + 1) % 4;
    end
    @(negedge clk);
    check(tag, model_addr());
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog addr_o=%h expected=done", a_out);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    a_in = 20'hFFFFF;
    repeat (2) @(negedge clk);
    check("R1", '0);
    rst_ni = 1'b1;

    // linear, all start offsets, runs of six advances (R5, R8)
    for (int st = 0; st < 4; st++) begin
      cyc("R2", 1, 0, 0, 0, 0, 20'h12340 | 20'(st));
      for (int k = 0; k < 6; k++) cyc("R5", 0, 0, 1, 1, 0, 20'h00000);
      cyc("R8", 0, 0, 1, 1, 0, 20'h00000);
    end
    // interleaved, all start offsets, order toggled mid-burst (R6, R9)
    for (int st = 0; st < 4; st++) begin
      cyc("R6", 1, 0, 1, 0, 1, 20'hABCD0 | 20'(st));
      for (int k = 0; k < 5; k++) cyc("R9", 0, 0, 1, 1, k[0], 20'h55555);
    end
    // stalls between advances (R4, R7)
    cyc("R2", 1, 0, 1, 0, 0, 20'h7FFFE);
    cyc("R4", 0, 0, 1, 0, 1, 20'h00001);
    cyc("R7", 0, 0, 1, 1, 0, 20'h00001);
    cyc("R7", 0, 0, 1, 1, 0, 20'h00001);
    cyc("R4", 0, 0, 0, 0, 0, 20'h00001);
    cyc("R4", 0, 0, 0, 0, 0, 20'h00001);
    // controller strobe gated by enable (R3)
    cyc("R3", 0, 1, 0, 0, 0, 20'h0F0F3);
    cyc("R3", 0, 1, 0, 1, 0, 20'h0F0F3);
    cyc("R3", 0, 1, 1, 0, 1, 20'h0F0F3);
    cyc("R3", 0, 0, 1, 1, 0, 20'h00000);
    // load beats adv, both strobes together (R10)
    cyc("R10", 1, 1, 1, 1, 0, 20'h33331);
    cyc("R10", 0, 0, 1, 1, 0, 20'h00000);
    cyc("R10", 0, 1, 1, 1, 1, 20'h44442);
    cyc("R10", 1, 0, 0, 1, 0, 20'h66663);
    // load every cycle (R11)
    for (int k = 0; k < 12; k++)
      cyc("R11", k[0], ~k[0], 1, k[1], k[2], 20'(32'h9E371 * (k + 1)));
    for (int k = 0; k < 3; k++) cyc("R11", 0, 0, 1, 1, 0, 20'h00000);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule